// File: doc/BRIEF.md
# Memory Port Power-Down and Sleep Controller

This block sits in front of one port of a synchronous dual-port memory and decides, on every clock, whether the port may touch the array and whether the port may drive its data outputs. The port has two chip enables, one active-low and one active-high. It also has a read/write strobe that is high for a read and an active-high sleep request that may change at any time. The array and the output pads stay outside the block. The block only produces the gates for them: an access select, a drive enable and a one-cycle flag for broken usage rules.

Any single deselected edge takes the port out of the driving state. The drive enable comes back only after a run of consecutive selected edges. The sleep request cuts the select and the drive enable at once, without waiting for a clock. A two-flop synchronised copy of the request drives the cycle-counted checks. Those checks watch the guard windows in which the port must stay deselected, before the request rises and after it falls, and they check that the first access after sleep is a read.

An edge is "selected" when the active-low enable is 0 and the active-high enable is 1 at that rising edge. Edge k is the first rising edge that samples the sleep request high. Edge m is the first rising edge that samples it low again.

Top module: `pds_port_ctrl`

## Requirements
- R1: While the reset input rst_ni is low, and after it is released, drv_en_o and viol_o are 0 until the port is selected.
- R2: After any rising edge at which ce_n_i is 1 or ce_i is 0, drv_en_o is 0.
- R3: drv_en_o becomes 1 after the second of two consecutive selected edges, and not after the first.
- R4: With the sleep request low and not yet seen by the synchroniser, sel_o equals (ce_n_i == 0 and ce_i == 1) combinationally, with no clock edge needed.
- R5: While sleep_i is 1, sel_o and drv_en_o are 0 at once, without waiting for a clock edge.
- R6: While asleep, toggling the enables and the read/write strobe has no effect. sel_o and drv_en_o stay 0 and viol_o stays 0. After waking, drv_en_o again needs two consecutive selected edges.
- R7: A selected edge at k-1, k-2 or k-3 raises viol_o for exactly the one cycle after edge k+1. A selected edge at k-4 or earlier does not raise viol_o.
- R8: A selected edge at m+1, m+2 or m+3 raises viol_o for the cycle after that edge. A selected edge at m itself does not.
- R9: On the first selected edge after m+1, if we_n_i is 0 (a write), viol_o is 1 for the following cycle. Writes on later selected edges do not raise viol_o, and neither does a first access that is a read.
- R10: A guard-window violation and a write-first violation on the same edge give one single-cycle pulse, and both conditions are cleared after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Active-low chip enable |
| ce_i | input | 1 | Active-high chip enable |
| we_n_i | input | 1 | Read/write strobe: 1 = read, 0 = write |
| sleep_i | input | 1 | Asynchronous active-high sleep request |
| sel_o | output | 1 | Array access permitted in this cycle |
| drv_en_o | output | 1 | Output drivers may be enabled |
| viol_o | output | 1 | One-cycle pulse marking a usage-rule violation |

## Verification
The exit guard window and the read-first rule can both apply to one selected edge. A write is placed on the last edge of the exit window, which is also the first access after sleep. The bench expects exactly one flag cycle, and then a second write on the next edge that raises nothing. The same sweep moves a single access across every edge around the sleep entry and around the sleep exit, and the bench computes from its distance whether the flag must rise. A separate case pulses the sleep request between two clock edges while the outputs are driving, to show that the cut is asynchronous and that the counted state is left untouched.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int unsigned WAKE_CYC_DEF = 2;
  localparam int unsigned GUARD_DEF    = 3;
endpackage

// File: rtl/pds_sync.sv
module pds_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic s1_o,
  output logic s2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_o <= 1'b0;
      s2_o <= 1'b0;
    end else begin
      s1_o <= d_i;
      s2_o <= s1_o;
    end
  end
endmodule

// File: rtl/pds_wake.sv
module pds_wake #(
  parameter int unsigned WAKE_CYC = pds_pkg::WAKE_CYC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic blk_i,
  output logic rdy_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || blk_i)  cnt_q <= '0;
    else if (cnt_q != FULL)   cnt_q <= cnt_q + 1'b1;
  end

  assign rdy_o = (cnt_q == FULL);
endmodule

// File: rtl/pds_guard.sv
module pds_guard #(
  parameter int unsigned GUARD = pds_pkg::GUARD_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wr_i,
  input  logic blk_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic viol_o
);
  localparam int unsigned GW = $clog2(GUARD + 1);

  // hist[0] = enable at previous edge; detection lags first sample by one edge
  logic [GUARD:0]  hist_q;
  logic [GW-1:0]   ex_cnt_q;
  logic            wake_q;
  logic            viol_q;
  logic            entry_v, exit_v, wfirst_v;

  assign entry_v  = rise_i & (|hist_q[GUARD:1]);
  assign exit_v   = (fall_i | (ex_cnt_q != '0)) & en_i;
  assign wfirst_v = wake_q & en_i & ~blk_i & wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q   <= '0;
      ex_cnt_q <= '0;
      wake_q   <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      hist_q <= {hist_q[GUARD-1:0], en_i};
      if (fall_i)                ex_cnt_q <= GW'(GUARD - 1);
      else if (ex_cnt_q != '0)   ex_cnt_q <= ex_cnt_q - 1'b1;
      if (rise_i)                wake_q <= 1'b0;
      else if (fall_i)           wake_q <= 1'b1;
      else if (en_i && !blk_i)   wake_q <= 1'b0;
      viol_q <= entry_v | exit_v | wfirst_v;
    end
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/pds_port_ctrl.sv
module pds_port_ctrl #(
  parameter int unsigned WAKE_CYC = pds_pkg::WAKE_CYC_DEF,
  parameter int unsigned GUARD    = pds_pkg::GUARD_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic ce_i,
  input  logic we_n_i,
  input  logic sleep_i,
  output logic sel_o,
  output logic drv_en_o,
  output logic viol_o
);
  logic en_w, s1, s2, blk_s, rise_s, fall_s, rdy;

  assign en_w   = ~ce_n_i & ce_i;
  assign blk_s  = s1 | s2;
  assign rise_s = s1 & ~s2;
  assign fall_s = ~s1 & s2;

  pds_sync u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sleep_i), .s1_o(s1), .s2_o(s2)
  );

  pds_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_w), .blk_i(blk_s), .rdy_o(rdy)
  );

  pds_guard #(.GUARD(GUARD)) u_guard (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_w), .wr_i(~we_n_i),
    .blk_i (blk_s), .rise_i(rise_s), .fall_i(fall_s), .viol_o(viol_o)
  );

  // raw sleep_i gates outputs asynchronously
  assign sel_o    = en_w & ~sleep_i & ~blk_s;
  assign drv_en_o = rdy  & ~sleep_i & ~blk_s;
endmodule

module pds_port_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_n_i,
  input logic ce_i,
  input logic sleep_i,
  input logic sel_o,
  input logic drv_en_o
);
  logic en_c;
  assign en_c = !ce_n_i && ce_i;

  assert_deselect_drops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_i || !ce_i) |=> !drv_en_o);

  assert_reenable_two_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> ($past(en_c, 1) && $past(en_c, 2)));

  assert_sel_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> en_c);

  assert_sleep_gates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (!sel_o && !drv_en_o));
endmodule

bind pds_port_ctrl pds_port_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_n_i(ce_n_i), .ce_i(ce_i),
  .sleep_i(sleep_i), .sel_o(sel_o), .drv_en_o(drv_en_o)
);

// File: tb/tb_pds_port_ctrl.sv
`timescale 1ns/1ps
module tb_pds_port_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ce_n_i = 1'b1, ce_i = 1'b0, we_n_i = 1'b1, sleep_i = 1'b0;
  logic sel_o, drv_en_o, viol_o;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  pds_port_ctrl dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one rising edge with given inputs; returns 1ns after the edge
  task automatic cyc(input logic cn, input logic c, input logic wn, input logic s);
    @(negedge clk_i);
    ce_n_i = cn; ce_i = c; we_n_i = wn; sleep_i = s;
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle(input logic s); cyc(1'b1, 1'b0, 1'b1, s); endtask
  task automatic rd();               cyc(1'b0, 1'b1, 1'b1, 1'b0); endtask
  task automatic wr();               cyc(1'b0, 1'b1, 1'b0, 1'b0); endtask

  task automatic sleep_enter();
    repeat (6) idle(1'b0);
    repeat (4) idle(1'b1);   // edges k..k+3
  endtask

  initial begin
    #(4 * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, even with the port selected
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1 drv in reset", drv_en_o, 1'b0);
    chk("R1 viol in reset", viol_o, 1'b0);
    idle(1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    idle(1'b0);
    chk("R1 drv after reset", drv_en_o, 1'b0);
    chk("R1 viol after reset", viol_o, 1'b0);

    // R3: two consecutive selected edges
    rd(); chk("R3 after one", drv_en_o, 1'b0);
    rd(); chk("R3 after two", drv_en_o, 1'b1);

    // R2/R3: each deselect pattern
    for (int p = 0; p < 3; p++) begin
      logic cn, c;
      cn = (p != 1);
      c  = (p == 0);
      cyc(cn, c, 1'b1, 1'b0); chk("R2 deselect", drv_en_o, 1'b0);
      rd();                   chk("R3 one after deselect", drv_en_o, 1'b0);
      rd();                   chk("R3 two after deselect", drv_en_o, 1'b1);
    end

    // R5: short sleep pulse between edges while driving
    @(negedge clk_i);
    ce_n_i = 1'b0; ce_i = 1'b1; sleep_i = 1'b1;
    #0.5;
    chk("R5 sel async", sel_o, 1'b0);
    chk("R5 drv async", drv_en_o, 1'b0);
    sleep_i = 1'b0;
    #0.5;
    chk("R5 drv returns", drv_en_o, 1'b1);
    chk("R4 sel returns", sel_o, 1'b1);
    @(posedge clk_i); #1;

    // R4: combinational select decode
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      ce_n_i = i[1]; ce_i = i[0]; sleep_i = 1'b0;
      #1;
      chk("R4 sel decode", sel_o, !i[1] && i[0]);
    end

    // R7: entry guard sweep, single access d edges before k
    for (int d = 1; d <= 5; d++) begin
      repeat (6) idle(1'b0);
      for (int j = 6; j >= 1; j--) begin
        if (j == d) rd(); else idle(1'b0);
      end
      idle(1'b1); chk("R7 no flag at k", viol_o, 1'b0);
      idle(1'b1); chk("R7 flag at k+1", viol_o, d <= 3);
      idle(1'b1); chk("R7 single cycle", viol_o, 1'b0);
      // R6: toggling while asleep
      for (int t = 0; t < 4; t++) begin
        cyc(1'b0, 1'b1, t[0], 1'b1);
        chk("R6 no flag asleep", viol_o, 1'b0);
        chk("R6 no drive asleep", drv_en_o, 1'b0);
        chk("R6 no select asleep", sel_o, 1'b0);
      end
      repeat (5) idle(1'b0);   // m..m+4
    end

    // R8: exit guard sweep, single read at m+d
    for (int d = 0; d <= 5; d++) begin
      sleep_enter();
      for (int e = 0; e <= 6; e++) begin
        if (e == d) rd(); else idle(1'b0);
        chk("R8 exit window", viol_o, (e == d) && (d >= 1) && (d <= 3));
      end
    end

    // R9: first access a write
    sleep_enter();
    repeat (5) idle(1'b0);
    wr(); chk("R9 write first", viol_o, 1'b1);
          chk("R6 drv one after wake", drv_en_o, 1'b0);
    wr(); chk("R9 later write", viol_o, 1'b0);
          chk("R6 drv two after wake", drv_en_o, 1'b1);

    // R9: first access a read
    sleep_enter();
    repeat (5) idle(1'b0);
    rd(); chk("R9 read first", viol_o, 1'b0);
    wr(); chk("R9 write after read", viol_o, 1'b0);

    // R10: window end coincides with write-first
    sleep_enter();
    repeat (3) idle(1'b0);   // m..m+2
    wr(); chk("R10 coincident pulse", viol_o, 1'b1);
    wr(); chk("R10 both cleared", viol_o, 1'b0);
    idle(1'b0); chk("R10 stays clear", viol_o, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule